// File: doc/BRIEF.md
# Nested User/System Page Table Walker

This block turns a user virtual address into a physical address in a system where the user page table is itself placed in system virtual space. The register that gives the user table base therefore holds a system virtual address. To read a user table entry, the walker first forms the system virtual address of that entry. It then translates that address through the system page table, whose base is physical. Only after that can it fetch the user entry. The walker reports either the final physical address or a fault code that says which of the two tables faulted.

A translate request enters on a valid/ready port. Both table base values are sampled when the request is accepted. The walker then issues at most two reads on a valid/ready memory read port: the system entry first, then the user entry. It never has more than one read in flight. Read data returns on a separate response handshake. The outcome leaves on a valid/ready result port. The walker handles one translation at a time and accepts no new request until the current result has been taken.

Back-pressure rules:
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- A read request, once raised, keeps `mem_rd_valid` high and `mem_rd_addr` unchanged until `mem_rd_ready` is seen.
- A read response is taken on an edge where `mem_rsp_valid` and `mem_rsp_ready` are both high.
- A result, once raised, keeps `res_valid`, `res_paddr` and `res_fault` unchanged until `res_ready` is seen.

Addresses are 32 bits with 4 KiB pages. Table entries are 32 bits wide and 4 bytes apart. In every entry, bit 0 is the present flag and bits 31:12 hold the physical page number.

Top module: `nested_page_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `res_valid` and `mem_rd_valid` are 0.
- R2: The first read of a walk uses address `sys_base + 4*(S >> 12)`, where `S = usr_base + 4*(vaddr >> 12)` is the system virtual address of the user entry.
- R3: When the system entry has bit 0 set, the second read uses address `{system_entry[31:12], S[11:0]}`.
- R4: When both entries have bit 0 set, the result carries `res_fault = 2'b00` and `res_paddr = {user_entry[31:12], vaddr[11:0]}`.
- R5: When the system entry has bit 0 clear, the result carries `res_fault = 2'b01` and `res_paddr = 0`, and no second read is issued.
- R6: When the system entry is present but the user entry has bit 0 clear, the result carries `res_fault = 2'b10` and `res_paddr = 0`.
- R7: Reads are issued one at a time, system entry before user entry. A raised read holds its valid and address stable while `mem_rd_ready` is low.
- R8: A raised result holds valid, address and fault stable while `res_ready` is low. `req_ready` stays low from acceptance until the result is taken.
- R9: The request address and both base values are sampled at acceptance. Changes on those inputs during a walk have no effect on its reads or result.
- R10: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | User virtual address to translate |
| usr_base | input | 32 | User table base, a system virtual address |
| sys_base | input | 32 | System table base, a physical address |
| mem_rd_valid | output | 1 | Table entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_paddr | output | 32 | Translated physical address, 0 on a fault |
| res_fault | output | 2 | 00 none, 01 system table fault, 10 user table fault |

## Verification
The walker has no fixed end-to-end latency. With a memory that is always ready and answers in the cycle after a read is accepted, `mem_rd_valid` rises one cycle after request acceptance and `res_valid` rises four edges after acceptance. Every cycle of read stall or response delay adds exactly one cycle to that. Because the latency varies, the scoreboard does not count cycles. The memory responder records each read address as it is accepted and checks that a stalled read stays stable. The monitor compares the whole walk (read count, read addresses, fault and address) only at the result handshake, and compares the held outputs on every stalled result cycle before it.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYS_RD,
    ST_SYS_WT,
    ST_USR_RD,
    ST_USR_WT,
    ST_DONE
  } walk_st_e;

  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_SYS  = 2'b01;
  localparam logic [1:0] FLT_USR  = 2'b10;
endpackage

// File: rtl/pw_pte_decode.sv
module pw_pte_decode #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int VALID_BIT = 0
) (
  input  logic [AW-1:0]           pte,
  output logic                    present,
  output logic [AW-PAGE_BITS-1:0] ppn
);
  assign present = pte[VALID_BIT];
  assign ppn     = pte[AW-1:PAGE_BITS];
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int AW         = 32,
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [AW-1:0]           vaddr,
  input  logic [AW-1:0]           usr_base,
  input  logic [AW-1:0]           sys_base,
  input  logic [AW-PAGE_BITS-1:0] sys_ppn,
  input  logic [AW-PAGE_BITS-1:0] leaf_ppn,
  output logic [AW-1:0]           sys_entry_pa,
  output logic [AW-1:0]           usr_entry_pa,
  output logic [AW-1:0]           final_pa
);
  logic [AW-1:0] usr_idx;
  logic [AW-1:0] sva;
  logic [AW-1:0] sys_idx;

  // R10: all sums are AW bits wide and wrap
  assign usr_idx      = (vaddr >> PAGE_BITS) << ENTRY_LOG2;
  assign sva          = usr_base + usr_idx;
  assign sys_idx      = (sva >> PAGE_BITS) << ENTRY_LOG2;
  assign sys_entry_pa = sys_base + sys_idx;
  assign usr_entry_pa = {sys_ppn, sva[PAGE_BITS-1:0]};
  assign final_pa     = {leaf_ppn, vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/pw_walk_ctrl.sv
module pw_walk_ctrl
  import pw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_vaddr,
  input  logic [AW-1:0]           usr_base,
  input  logic [AW-1:0]           sys_base,
  output logic [AW-1:0]           vaddr_q,
  output logic [AW-1:0]           ubase_q,
  output logic [AW-1:0]           sbase_q,
  output logic [AW-PAGE_BITS-1:0] sppn_q,
  input  logic [AW-1:0]           sys_entry_pa,
  input  logic [AW-1:0]           usr_entry_pa,
  input  logic [AW-1:0]           final_pa,
  input  logic                    rsp_present,
  input  logic [AW-PAGE_BITS-1:0] rsp_ppn,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [AW-1:0]           mem_rd_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [AW-1:0]           res_paddr,
  output logic [1:0]              res_fault
);
  walk_st_e      st_q, st_d;
  logic [AW-1:0] paddr_q;
  logic [1:0]    fault_q;
  logic          rsp_take;

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_rd_valid  = (st_q == ST_SYS_RD) || (st_q == ST_USR_RD);
  assign mem_rd_addr   = (st_q == ST_USR_RD) ? usr_entry_pa : sys_entry_pa;
  assign mem_rsp_ready = (st_q == ST_SYS_WT) || (st_q == ST_USR_WT);
  assign res_valid     = (st_q == ST_DONE);
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;
  assign rsp_take      = mem_rsp_valid && mem_rsp_ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_SYS_RD;
      ST_SYS_RD: if (mem_rd_ready) st_d = ST_SYS_WT;
      ST_SYS_WT: if (mem_rsp_valid) st_d = rsp_present ? ST_USR_RD : ST_DONE;
      ST_USR_RD: if (mem_rd_ready) st_d = ST_USR_WT;
      ST_USR_WT: if (mem_rsp_valid) st_d = ST_DONE;
      ST_DONE:   if (res_ready) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      ubase_q <= '0;
      sbase_q <= '0;
      sppn_q  <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid) begin
        vaddr_q <= req_vaddr;
        ubase_q <= usr_base;
        sbase_q <= sys_base;
      end
      if (st_q == ST_SYS_WT && rsp_take) begin
        if (rsp_present) begin
          sppn_q <= rsp_ppn;
        end else begin
          paddr_q <= '0;
          fault_q <= FLT_SYS;
        end
      end
      if (st_q == ST_USR_WT && rsp_take) begin
        paddr_q <= rsp_present ? final_pa : '0;
        fault_q <= rsp_present ? FLT_NONE : FLT_USR;
      end
    end
  end

  // Tracking state for the assertions below
  logic       rd_pend;
  logic [1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_cnt  <= '0;
    end else begin
      if (mem_rd_valid && mem_rd_ready) rd_pend <= 1'b1;
      else if (rsp_take) rd_pend <= 1'b0;
      if (req_valid && req_ready) rd_cnt <= '0;
      else if (mem_rd_valid && mem_rd_ready) rd_cnt <= rd_cnt + 2'd1;
    end
  end

  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !rd_pend);
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault));
  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault != FLT_NONE) |-> res_paddr == '0);
  a_r5_sys_fault_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault == FLT_SYS) |-> rd_cnt == 2'd1);
  a_r4_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault != FLT_SYS) |-> rd_cnt == 2'd2);
  a_r6_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_fault));
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid || mem_rsp_ready || res_valid |-> !req_ready);
endmodule

// File: rtl/nested_page_walker.sv
module nested_page_walker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int VALID_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] usr_base,
  input  logic [ADDR_W-1:0] sys_base,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [1:0]        res_fault
);
  localparam int PPN_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] vaddr_q, ubase_q, sbase_q;
  logic [PPN_W-1:0]  sppn_q, rsp_ppn;
  logic              rsp_present;
  logic [ADDR_W-1:0] sys_entry_pa, usr_entry_pa, final_pa;

  pw_pte_decode #(.AW(ADDR_W), .PAGE_BITS(PAGE_BITS), .VALID_BIT(VALID_BIT)) u_dec (
    .pte(mem_rsp_data), .present(rsp_present), .ppn(rsp_ppn)
  );

  pw_addr_gen #(.AW(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_LOG2(ENTRY_LOG2)) u_agen (
    .vaddr(vaddr_q), .usr_base(ubase_q), .sys_base(sbase_q),
    .sys_ppn(sppn_q), .leaf_ppn(rsp_ppn),
    .sys_entry_pa(sys_entry_pa), .usr_entry_pa(usr_entry_pa), .final_pa(final_pa)
  );

  pw_walk_ctrl #(.AW(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .usr_base(usr_base), .sys_base(sys_base),
    .vaddr_q(vaddr_q), .ubase_q(ubase_q), .sbase_q(sbase_q), .sppn_q(sppn_q),
    .sys_entry_pa(sys_entry_pa), .usr_entry_pa(usr_entry_pa), .final_pa(final_pa),
    .rsp_present(rsp_present), .rsp_ppn(rsp_ppn),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_fault(res_fault)
  );
endmodule

// File: tb/tb_nested_page_walker.sv
`timescale 1ns/1ps
module tb_nested_page_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0, usr_base = '0, sys_base = '0;
  logic mem_rd_valid, mem_rd_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rd_addr, mem_rsp_data;
  logic res_valid, res_ready;
  logic [31:0] res_paddr;
  logic [1:0] res_fault;

  always #2 clk = ~clk;  // 250 MHz

  nested_page_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .usr_base(usr_base), .sys_base(sys_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_fault(res_fault)
  );

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  flt;
    int          nrd;
    logic [31:0] a0;
    logic [31:0] a1;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] seen_q[$];
  logic [31:0] mem_model[logic [31:0]];
  int checks = 0, errors = 0;
  int cfg_stall = 0, cfg_lat = 0, hold_left = 0, done_cnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Memory responder: stalls, records accepted read addresses, returns model data
  initial begin
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        logic [31:0] a;
        a = mem_rd_addr;
        for (int i = 0; i < cfg_stall; i++) begin
          @(negedge clk);
          chk(mem_rd_valid && mem_rd_addr == a, "R7 read held under stall", mem_rd_addr, a);
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        seen_q.push_back(a);
        for (int i = 0; i < cfg_lat; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_model.exists(a) ? mem_model[a] : 32'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // Result monitor / scoreboard
  initial begin
    res_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q[0];
        chk(!req_ready, "R8 busy until result taken", {31'b0, req_ready}, 32'h0);
        if (hold_left > 0) begin
          res_ready = 1'b0;
          hold_left--;
          chk(res_paddr == e.pa && res_fault == e.flt, "R8 result held",
              res_paddr, e.pa);
        end else begin
          string ftag;
          res_ready = 1'b1;
          void'(exp_q.pop_front());
          ftag = (e.flt == 2'b01) ? "R5 fault code" :
                 (e.flt == 2'b10) ? "R6 fault code" : "R4 fault code";
          chk(res_fault == e.flt, ftag, {30'b0, res_fault}, {30'b0, e.flt});
          chk(res_paddr == e.pa, (e.flt == 2'b00) ? "R4 physical address" : "R5 R6 zero address",
              res_paddr, e.pa);
          chk(seen_q.size() == e.nrd, "R7 read count", seen_q.size(), e.nrd);
          if (seen_q.size() > 0)
            chk(seen_q[0] == e.a0, "R2 system entry address", seen_q[0], e.a0);
          if (seen_q.size() > 1 && e.nrd > 1)
            chk(seen_q[1] == e.a1, "R3 user entry address", seen_q[1], e.a1);
          seen_q.delete();
          done_cnt++;
        end
      end else begin
        res_ready = 1'b0;
      end
    end
  end

  // Driver: builds the memory model, pushes the expected item, issues the request
  task automatic walk(input logic [31:0] va, input logic [31:0] ub, input logic [31:0] sb,
                      input logic [31:0] spte, input logic [31:0] upte,
                      input int stall, input int lat, input int hold, input bit scramble);
    exp_t e;
    logic [31:0] sva, sa, ua;
    int target;
    sva = ub + ((va >> 12) << 2);
    sa  = sb + ((sva >> 12) << 2);
    ua  = {spte[31:12], sva[11:0]};
    mem_model.delete();
    mem_model[sa] = spte;
    if (spte[0]) mem_model[ua] = upte;
    e.a0 = sa;
    e.a1 = ua;
    if (!spte[0]) begin
      e.flt = 2'b01; e.pa = 32'h0; e.nrd = 1;
    end else if (!upte[0]) begin
      e.flt = 2'b10; e.pa = 32'h0; e.nrd = 2;
    end else begin
      e.flt = 2'b00; e.pa = {upte[31:12], va[11:0]}; e.nrd = 2;
    end
    exp_q.push_back(e);
    cfg_stall = stall;
    cfg_lat = lat;
    hold_left = hold;
    target = done_cnt + 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    usr_base = ub;
    sys_base = sb;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin  // R9: changes after acceptance must not matter
      req_vaddr = ~va;
      usr_base = ub ^ 32'h1357_9000;
      sys_base = sb ^ 32'h0246_8000;
    end
    while (done_cnt != target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready in reset", {31'b0, req_ready}, 32'h1);
    chk(res_valid == 1'b0, "R1 res_valid in reset", {31'b0, res_valid}, 32'h0);
    chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid in reset", {31'b0, mem_rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !res_valid && !mem_rd_valid, "R1 idle after reset",
        {29'b0, req_ready, res_valid, mem_rd_valid}, 32'h4);

    // R4 basic success
    walk(32'h0040_3ABC, 32'h8000_1000, 32'h0010_0000, 32'h0002_3001, 32'h0ABC_D001, 0, 0, 0, 0);
    // R5 system table fault: single read, zero address
    walk(32'h1234_5678, 32'h8000_1000, 32'h0010_0000, 32'h0002_3000, 32'h0ABC_D001, 0, 0, 0, 0);
    // R6 user table fault
    walk(32'h0040_3ABC, 32'h8000_1000, 32'h0010_0000, 32'h0003_7001, 32'h0ABC_D000, 1, 1, 0, 0);
    // R10 wrap of both sums
    walk(32'hFFFF_F123, 32'hFFFF_F000, 32'hFFFF_FF00, 32'h0055_5001, 32'h0066_6001, 0, 0, 0, 0);
    // R7 R8 stalls, response delay and result back-pressure
    walk(32'h0000_1FFF, 32'h8000_0FFC, 32'h0020_0000, 32'h0011_1001, 32'hFEDC_B001, 3, 2, 3, 0);
    // R9 inputs changed during the walk
    walk(32'h7654_3210, 32'hC000_0000, 32'h0030_0000, 32'h0044_4001, 32'h1357_9001, 2, 3, 2, 1);
    // R9 with a system fault and a held result
    walk(32'h0ABC_0000, 32'h9000_0800, 32'h0040_0000, 32'hFFFF_F000, 32'h0, 1, 0, 2, 1);
    // R3 system offset carries into the user entry address
    walk(32'h00FF_F004, 32'hA000_0A00, 32'h0050_0000, 32'h0077_7001, 32'h0088_8001, 0, 1, 1, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", done_cnt, 8);
    finish_run();
  end
endmodule